// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches nine external interrupt inputs and turns their activity into latched, maskable interrupt requests. Bit position 0 is the line reserved for non-maskable use by the interrupt fabric, and bit positions 1 to 8 are general lines 1 to 8. Every line has its own settings. It can be enabled or disabled. It can sense an edge or a level, with a polarity for each. It can pass through a glitch filter, and it can take either a two-flop synchronized path or a bypass path with no synchronizer.

Software reaches the block through a small word-addressed register bus with single-cycle writes and combinational reads. The mask and the enable state can only be changed through write-only set and clear registers, and each has a read-only mirror. Pending status is read-only and is cleared by writing ones to a separate write-only register. A test register can replace the pin inputs with register bits. The block drives one combined interrupt request and a clock-request signal. The clock request stays high while any line is masked in or enabled.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, every readable register returns zero and both `irq_out` and `clk_req` are low.
- R2: Writing a 1 to bit i at offset 0x00 sets mask bit i. Writing a 1 to bit i at offset 0x04 clears it. Zero bits leave the mask unchanged. The mask reads back at offset 0x08.
- R3: Line-enable bits follow the same scheme: set at offset 0x30, clear at offset 0x34, read back at offset 0x38.
- R4: Status bit i reads at offset 0x0C. It can become 1 only while line i is enabled and its configured condition occurs. Offset 0x14 bit i selects level sensing (1) or edge sensing (0). For edge sensing, offset 0x18 bit i selects rising (1) or falling (0). For level sensing, offset 0x1C bit i selects active-high (1) or active-low (0).
- R5: Writing a 1 to bit i at offset 0x10 clears status bit i. If the line's condition is present in the same cycle, the set wins. A level-sensed line sets its status again on every cycle that its level stays active.
- R6: The input is sampled on rising clock edges. When offset 0x28 bit i is 0 (synchronized path), a change that is present before edge 1 shows in status after edge 4. When that bit is 1 (bypass path), it shows after edge 2.
- R7: When offset 0x20 bit i is 1, a new input value is accepted only after three consecutive equal samples. A two-cycle pulse is ignored and a three-cycle pulse is detected. With the filter off on the bypass path, a one-cycle pulse is detected.
- R8: Offset 0x24 bit 31 enables test mode. In test mode, bits 8..0 of that register drive lines 8..0 and the pins are ignored. The register reads back bit 31 and bits 8..0.
- R9: `irq_out` is high exactly when some line has both its status bit and its mask bit set. `clk_req` is high exactly when the mask or the enable register is nonzero.
- R10: Writes to the read-only offsets 0x08, 0x0C and 0x38, and to the reserved offset 0x2C, change no state. Write-only offsets read as zero. The configuration registers at 0x14, 0x18, 0x1C, 0x20 and 0x28 read back their nine low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte address; bits 5..2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_in | input | 9 | External interrupt inputs, bit 0 is the non-maskable line |
| irq_out | output | 1 | Combined interrupt request |
| clk_req | output | 1 | Clock request |

## Verification
The main collision is a software status clear that lands in the same cycle as a new detection on that line. The bench aligns them on purpose: it raises an input on the bypass path and times the clear write to the edge at which the edge detector fires. It then expects the status bit to read 1, and a later clear with no event to read 0. A level-sensed line that is still active is also cleared, and it must read back as pending. In the random phase a clear of all lines is followed at once by new input values, so old level conditions, new edges and the clear overlap. Each pending word is compared with a bench function of the old and new inputs.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int XIRQ_LINES    = 9;
    localparam int XIRQ_DW       = 32;
    localparam int XIRQ_AW       = 6;
    localparam int XIRQ_TEST_BIT = 31;

    // word index = byte address bits 5..2; the map order is decoded by the bus
    typedef enum logic [3:0] {
        RG_IMSET = 4'd0,
        RG_IMCLR = 4'd1,
        RG_IMASK = 4'd2,
        RG_STAT  = 4'd3,
        RG_STCLR = 4'd4,
        RG_MODE  = 4'd5,
        RG_EDGE  = 4'd6,
        RG_LEVEL = 4'd7,
        RG_FILT  = 4'd8,
        RG_TEST  = 4'd9,
        RG_ASYNC = 4'd10,
        RG_RSVD  = 4'd11,
        RG_LNSET = 4'd12,
        RG_LNCLR = 4'd13,
        RG_LNEN  = 4'd14
    } xirq_reg_e;

    typedef struct packed {
        logic lvl_sense;    // 1: level, 0: edge
        logic rising;       // edge polarity
        logic act_high;     // level polarity
        logic filt_on;      // glitch filter
        logic bypass_sync;  // skip the synchronizer
    } xirq_lcfg_t;

    function automatic logic [3:0] word_index(input logic [XIRQ_AW-1:0] a);
        return a[5:2];
    endfunction

endpackage

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int N  = XIRQ_LINES,
    parameter int DW = XIRQ_DW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [XIRQ_AW-1:0]     bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [N-1:0]           stat,
    output logic [N-1:0]           mask,
    output logic [N-1:0]           line_en,
    output logic [N-1:0]           stat_clr,
    output xirq_lcfg_t [N-1:0]     cfg,
    output logic                   test_on,
    output logic [N-1:0]           test_val
);

    logic [3:0]   idx;
    logic [N-1:0] w_n;
    logic [N-1:0] mask_q, en_q, mode_q, edge_q, lvl_q, filt_q, async_q, tval_q;
    logic         ton_q;
    logic         wdata_unused;

    assign idx          = word_index(bus_addr);
    assign w_n          = bus_wdata[N-1:0];
    assign wdata_unused = ^{bus_wdata[DW-2:N], bus_addr[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            en_q    <= '0;
            mode_q  <= '0;
            edge_q  <= '0;
            lvl_q   <= '0;
            filt_q  <= '0;
            async_q <= '0;
            tval_q  <= '0;
            ton_q   <= 1'b0;
        end else if (bus_wr) begin
            case (idx)
                RG_IMSET: mask_q  <= mask_q | w_n;
                RG_IMCLR: mask_q  <= mask_q & ~w_n;
                RG_LNSET: en_q    <= en_q | w_n;
                RG_LNCLR: en_q    <= en_q & ~w_n;
                RG_MODE:  mode_q  <= w_n;
                RG_EDGE:  edge_q  <= w_n;
                RG_LEVEL: lvl_q   <= w_n;
                RG_FILT:  filt_q  <= w_n;
                RG_ASYNC: async_q <= w_n;
                RG_TEST: begin
                    tval_q <= w_n;
                    ton_q  <= bus_wdata[XIRQ_TEST_BIT];
                end
                default: ;
            endcase
        end
    end

    assign stat_clr = (bus_wr && idx == RG_STCLR) ? w_n : '0;

    always_comb begin
        bus_rdata = '0;
        case (idx)
            RG_IMASK: bus_rdata[N-1:0] = mask_q;
            RG_STAT:  bus_rdata[N-1:0] = stat;
            RG_MODE:  bus_rdata[N-1:0] = mode_q;
            RG_EDGE:  bus_rdata[N-1:0] = edge_q;
            RG_LEVEL: bus_rdata[N-1:0] = lvl_q;
            RG_FILT:  bus_rdata[N-1:0] = filt_q;
            RG_ASYNC: bus_rdata[N-1:0] = async_q;
            RG_LNEN:  bus_rdata[N-1:0] = en_q;
            RG_TEST: begin
                bus_rdata[N-1:0]           = tval_q;
                bus_rdata[XIRQ_TEST_BIT]   = ton_q;
            end
            default: ;
        endcase
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg[i].lvl_sense   = mode_q[i];
            cfg[i].rising      = edge_q[i];
            cfg[i].act_high    = lvl_q[i];
            cfg[i].filt_on     = filt_q[i];
            cfg[i].bypass_sync = async_q[i];
        end
    end

    assign mask     = mask_q;
    assign line_en  = en_q;
    assign test_on  = ton_q;
    assign test_val = tval_q;

    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == RG_IMSET) |=> ((mask_q & $past(w_n)) == $past(w_n)));

    p_mask_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == RG_IMCLR) |=> ((mask_q & $past(w_n)) == '0));

    p_en_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == RG_LNCLR) |=> ((en_q & $past(w_n)) == '0));

    p_ro_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (idx == RG_IMASK || idx == RG_STAT || idx == RG_LNEN || idx == RG_RSVD))
        |=> ($stable(mask_q) && $stable(en_q)));

endmodule

// File: rtl/xirq_cond.sv
module xirq_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic filt_on,
    input  logic bypass_sync,
    output logic cur,
    output logic prv
);

    localparam int HW = FILT_LEN - 1;

    logic [SYNC_STAGES-1:0] sy_q;
    logic [HW-1:0]          hist_q;
    logic                   cur_q, prv_q;
    logic                   sel, agree, nxt;

    assign sel   = bypass_sync ? raw : sy_q[SYNC_STAGES-1];
    assign agree = (sel & (&hist_q)) | (~sel & ~(|hist_q));
    assign nxt   = filt_on ? (agree ? sel : cur_q) : sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy_q   <= '0;
            hist_q <= '0;
            cur_q  <= 1'b0;
            prv_q  <= 1'b0;
        end else begin
            sy_q   <= (sy_q << 1) | SYNC_STAGES'(raw);
            hist_q <= (hist_q << 1) | HW'(sel);
            cur_q  <= nxt;
            prv_q  <= cur_q;
        end
    end

    assign cur = cur_q;
    assign prv = prv_q;

    p_filter_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (filt_on && sel != hist_q[0]) |=> $stable(cur_q));

endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    input  xirq_lcfg_t cfg,
    input  logic       en,
    input  logic       clr,
    output logic       stat
);

    logic cur, prv, hit, stat_q;

    xirq_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_cond (
        .clk        (clk),
        .rst        (rst),
        .raw        (raw),
        .filt_on    (cfg.filt_on),
        .bypass_sync(cfg.bypass_sync),
        .cur        (cur),
        .prv        (prv)
    );

    always_comb begin
        if (cfg.lvl_sense)
            hit = (cur == cfg.act_high);
        else if (cfg.rising)
            hit = cur & ~prv;
        else
            hit = ~cur & prv;
        hit = hit & en;
    end

    // a detection in the clear cycle wins
    always_ff @(posedge clk) begin
        if (rst)      stat_q <= 1'b0;
        else if (hit) stat_q <= 1'b1;
        else if (clr) stat_q <= 1'b0;
    end

    assign stat = stat_q;

    p_stat_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q) |-> $past(en));

    p_level_set_r5: assert property (@(posedge clk) disable iff (rst)
        (en && cfg.lvl_sense && cur == cfg.act_high) |=> stat_q);

    p_clr_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !en) |=> !stat_q);

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int N_LINES     = XIRQ_LINES,
    parameter int DATA_W      = XIRQ_DW,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [XIRQ_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_LINES-1:0]  line_in,
    output logic                irq_out,
    output logic                clk_req
);

    logic [N_LINES-1:0]       stat, mask, line_en, stat_clr, test_val, raw;
    xirq_lcfg_t [N_LINES-1:0] cfg;
    logic                     test_on;

    xirq_regs #(
        .N (N_LINES),
        .DW(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .stat     (stat),
        .mask     (mask),
        .line_en  (line_en),
        .stat_clr (stat_clr),
        .cfg      (cfg),
        .test_on  (test_on),
        .test_val (test_val)
    );

    assign raw = test_on ? test_val : line_in;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        xirq_line #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_line (
            .clk (clk),
            .rst (rst),
            .raw (raw[g]),
            .cfg (cfg[g]),
            .en  (line_en[g]),
            .clr (stat_clr[g]),
            .stat(stat[g])
        );
    end

    assign irq_out = |(stat & mask);
    assign clk_req = (|mask) | (|line_en);

    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (|mask));

    p_clkreq_en_r9: assert property (@(posedge clk) disable iff (rst)
        (|line_en) |-> clk_req);

endmodule

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;

    localparam logic [5:0] A_IMSET = 6'h00, A_IMCLR = 6'h04, A_IMASK = 6'h08,
                           A_STAT  = 6'h0C, A_STCLR = 6'h10, A_MODE  = 6'h14,
                           A_EDGE  = 6'h18, A_LEVEL = 6'h1C, A_FILT  = 6'h20,
                           A_TEST  = 6'h24, A_ASYNC = 6'h28, A_RSVD  = 6'h2C,
                           A_LNSET = 6'h30, A_LNCLR = 6'h34, A_LNEN  = 6'h38;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [8:0]  line_in;
    logic        irq_out, clk_req;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    xirq_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .line_in  (line_in),
        .irq_out  (irq_out),
        .clk_req  (clk_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic setup(input logic [8:0] en, md, ed, lv, fl, as, mk);
        wr(A_LNCLR, 32'h1FF); wr(A_LNSET, {23'd0, en});
        wr(A_MODE, {23'd0, md}); wr(A_EDGE, {23'd0, ed}); wr(A_LEVEL, {23'd0, lv});
        wr(A_FILT, {23'd0, fl}); wr(A_ASYNC, {23'd0, as});
        wr(A_IMCLR, 32'h1FF); wr(A_IMSET, {23'd0, mk});
        repeat (10) @(negedge clk);
        wr(A_STCLR, 32'h1FF);
    endtask

    function automatic logic [8:0] exp_stat(input logic [8:0] en, md, rs, hi, ov, nv);
        logic [8:0] lvl_hit, edg_hit;
        lvl_hit = md & (~(nv ^ hi) | ~(ov ^ hi));
        edg_hit = ~md & ((rs & nv & ~ov) | (~rs & ~nv & ov));
        return en & (lvl_hit | edg_hit);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [8:0]  en, md, rs, hi, fl, as, mk, ov, nv, es;
        void'($urandom(32'd1234));
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; line_in = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 15; a++) begin
            peek(6'(a * 4), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 irq_out after reset", {31'd0, irq_out}, 32'h0);
        check("R1 clk_req after reset", {31'd0, clk_req}, 32'h0);

        // R2 mask set/clear
        wr(A_IMSET, 32'h005); wr(A_IMCLR, 32'h004); wr(A_IMSET, 32'h0);
        peek(A_IMASK, d); check("R2 mask set/clear", d, 32'h001);
        check("R9 clk_req from mask", {31'd0, clk_req}, 32'h1);
        // R10 read-only/reserved writes ignored, write-only reads zero
        wr(A_IMASK, 32'h1FF); wr(A_RSVD, 32'h1FF);
        peek(A_IMASK, d); check("R10 write to mask mirror ignored", d, 32'h001);
        peek(A_IMSET, d); check("R10 write-only reads zero", d, 32'h0);
        wr(A_IMCLR, 32'h1FF);
        check("R9 clk_req low when idle", {31'd0, clk_req}, 32'h0);

        // R3 enable set/clear
        wr(A_LNSET, 32'h0F0); wr(A_LNCLR, 32'h030);
        peek(A_LNEN, d); check("R3 enable set/clear", d, 32'h0C0);
        check("R9 clk_req from enable", {31'd0, clk_req}, 32'h1);
        wr(A_LNEN, 32'hFFFF);
        peek(A_LNEN, d); check("R10 write to enable mirror ignored", d, 32'h0C0);
        wr(A_MODE, 32'hFFFF_FFFF);
        peek(A_MODE, d); check("R10 config readback width", d, 32'h1FF);
        wr(A_MODE, 32'h0);

        // R6 synchronized path latency, line 1 rising
        setup(9'h002, 9'h000, 9'h002, 9'h000, 9'h000, 9'h000, 9'h000);
        @(negedge clk); line_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        peek(A_STAT, d); check("R6 sync path not yet after edge 3", d, 32'h0);
        @(negedge clk);
        peek(A_STAT, d); check("R6 sync path set after edge 4", d, 32'h002);

        // R6 bypass path latency, line 2 rising
        setup(9'h004, 9'h000, 9'h004, 9'h000, 9'h000, 9'h004, 9'h000);
        @(negedge clk); line_in[2] = 1'b1;
        @(negedge clk);
        peek(A_STAT, d); check("R6 bypass not yet after edge 1", d, 32'h0);
        @(negedge clk);
        peek(A_STAT, d); check("R6 bypass set after edge 2", d, 32'h004);

        // R7 filter on line 3 (bypass path, rising)
        setup(9'h008, 9'h000, 9'h008, 9'h000, 9'h008, 9'h008, 9'h000);
        @(negedge clk); line_in[3] = 1'b1;
        repeat (2) @(negedge clk); line_in[3] = 1'b0;
        repeat (8) @(negedge clk);
        peek(A_STAT, d); check("R7 two-cycle pulse rejected", d, 32'h0);
        line_in[3] = 1'b1;
        repeat (3) @(negedge clk); line_in[3] = 1'b0;
        repeat (8) @(negedge clk);
        peek(A_STAT, d); check("R7 three-cycle pulse accepted", d, 32'h008);
        setup(9'h008, 9'h000, 9'h008, 9'h000, 9'h000, 9'h008, 9'h000);
        @(negedge clk); line_in[3] = 1'b1;
        @(negedge clk); line_in[3] = 1'b0;
        repeat (6) @(negedge clk);
        peek(A_STAT, d); check("R7 one-cycle pulse without filter", d, 32'h008);

        // R5 set wins over clear, line 4 bypass rising
        setup(9'h010, 9'h000, 9'h010, 9'h000, 9'h000, 9'h010, 9'h010);
        @(negedge clk); line_in[4] = 1'b1;
        wr(A_STCLR, 32'h010);
        peek(A_STAT, d); check("R5 detection beats same-cycle clear", d, 32'h010);
        check("R9 irq_out with status and mask", {31'd0, irq_out}, 32'h1);
        wr(A_STCLR, 32'h010);
        peek(A_STAT, d); check("R5 clear without event", d, 32'h0);
        check("R9 irq_out low after clear", {31'd0, irq_out}, 32'h0);

        // R5 level re-set, line 5 active-high
        line_in[5] = 1'b1;
        setup(9'h020, 9'h020, 9'h000, 9'h020, 9'h000, 9'h000, 9'h000);
        wr(A_STCLR, 32'h020);
        peek(A_STAT, d); check("R5 active level re-sets after clear", d, 32'h020);
        check("R9 irq_out masked off", {31'd0, irq_out}, 32'h0);

        // R4 disabled line ignores its edge, line 7
        setup(9'h000, 9'h000, 9'h080, 9'h000, 9'h000, 9'h080, 9'h000);
        @(negedge clk); line_in[7] = 1'b1;
        repeat (8) @(negedge clk);
        peek(A_STAT, d); check("R4 disabled line stays clear", d, 32'h0);

        // R8 test mode, line 6 rising
        line_in = '0;
        setup(9'h040, 9'h000, 9'h040, 9'h000, 9'h000, 9'h000, 9'h000);
        wr(A_TEST, 32'h8000_0000);
        wr(A_STCLR, 32'h1FF);
        line_in[6] = 1'b1;
        repeat (10) @(negedge clk);
        peek(A_STAT, d); check("R8 pin ignored in test mode", d, 32'h0);
        wr(A_TEST, 32'h8000_0040);
        repeat (10) @(negedge clk);
        peek(A_STAT, d); check("R8 test bit drives line", d, 32'h040);
        peek(A_TEST, d); check("R8 test readback", d, 32'h8000_0040);
        wr(A_TEST, 32'h0);

        // R4/R5/R9 random configurations and transitions
        ov = line_in;
        for (int it = 0; it < 60; it++) begin
            en = 9'($urandom); md = 9'($urandom); rs = 9'($urandom);
            hi = 9'($urandom); fl = 9'($urandom); as = 9'($urandom);
            mk = 9'($urandom); nv = 9'($urandom);
            if (it % 8 == 0) nv = ~ov;
            setup(en, md, rs, hi, fl, as, mk);
            line_in = nv;
            repeat (12) @(negedge clk);
            es = exp_stat(en, md, rs, hi, ov, nv);
            peek(A_STAT, d); check("R4 random status", d, {23'd0, es});
            check("R9 random irq_out", {31'd0, irq_out}, {31'd0, |(es & mk)});
            check("R9 random clk_req", {31'd0, clk_req}, {31'd0, (|mk) | (|en)});
            ov = nv;
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule